// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block computes the next data-write pointer for a processor's address unit and, when its reordering mode is switched on, steps that pointer in bit-reversed order. A radix-2 FFT keeps its samples in natural order in memory, while the butterflies produce them in bit-reversed order. The block lets each result be stored at the reordered location with a single indirect write, so no separate shuffle pass is needed afterwards. Each request gives the current pointer, a step value (the pivot, normally half the buffer length in words), an enable, the index of the pointer register in use, an addressing-mode code and a byte/word flag. One clock later the block returns the effective address for the access and the value to write back into the pointer register.

The reordered step uses a reverse-carry add. The pivot is added at its own bit position, and every carry moves one place toward the least significant bit. A carry that leaves bit 0 is dropped. This gives the same result as reversing the word index, adding the reversed pivot and reversing the sum back. Address bits above the buffer span are never changed, so a buffer whose start is aligned to its own size is walked completely and then wraps back to its first entry. While the reordered path is in use, the block raises a signal that turns off modulo correction on the write side.

Top module: `brev_wr_agen`

## Requirements
- R1: The reordered path is taken (and `rev_applied` is 1) only when all of these hold: `rev_en` is 1, `ptr_sel` is not 15, `is_byte` is 0, and `amode` is 2 (post-increment) or 4 (pre-increment).
- R2: When the reordered path is not taken, the pointer moves sequentially. `amode` 2 and 4 add the access size, `amode` 1 and 3 subtract it, and all other codes (0, 5, 6, 7) leave it unchanged. The access size is 1 when `is_byte` is 1 and 2 otherwise. All arithmetic is modulo 2^16. This applies even when `rev_en` is 1.
- R3: When the reordered path is taken, the word index `ptr_in[15:1]` is combined with `modifier` by a reverse-carry add. The result equals rev(rev(index) + rev(modifier)), where rev mirrors 15 bits and the sum is cut to 15 bits. The normal access-size offset is not applied.
- R4: When the reordered path is taken, bit 0 of both `ea_out` and `ptr_next` is 0. The new word index is placed in bits 15:1, so each word step is two bytes.
- R5: For the pre-modes (`amode` 3 and 4), `ea_out` equals the updated pointer. For all other modes, `ea_out` is the old pointer, with bit 0 cleared when the reordered path is taken. `ptr_next` is always the updated pointer.
- R6: `modulo_inhibit` is 1 exactly when `rev_applied` is 1.
- R7: All results are registered. They appear in the cycle after a request with `req_valid` = 1, and `out_valid` is 1 in that cycle. When `req_valid` is 0, `out_valid` goes to 0 and all other outputs hold their values.
- R8: Synchronous reset clears every output to 0.
- R9: Take a start address whose low bits are zero across a 2^N-word buffer, a pivot of 2^(N-1), and repeated post-increment writes with the result fed back each time. Write k then lands on word (start/2) + rev_N(k), giving the word order 0, 8, 4, 12, 2, 10 and so on for N = 4. After 2^N writes the pointer is back at the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| ptr_in | input | 16 | Current pointer (byte address) |
| modifier | input | 15 | Pivot / reordered step, in words |
| rev_en | input | 1 | Reordering mode enable |
| ptr_sel | input | 4 | Index of pointer register in use (15 = stack) |
| amode | input | 3 | Addressing mode code (1 post-dec, 2 post-inc, 3 pre-dec, 4 pre-inc, others no update) |
| is_byte | input | 1 | Byte-sized access |
| out_valid | output | 1 | Results valid this cycle |
| ea_out | output | 16 | Effective address for the access |
| ptr_next | output | 16 | Value to write back into the pointer register |
| rev_applied | output | 1 | Reordered arithmetic was used |
| modulo_inhibit | output | 1 | Disables write-side modulo correction |

## Verification
The properties assume that `ptr_sel`, `amode`, `is_byte` and `ptr_in` sampled in the request cycle are the values that governed the result one cycle later. They also assume that reset is not active in that cycle. The stimulus changes inputs only on falling edges and always brackets each request with an idle cycle, so this holds. The stimulus also assumes buffers are aligned to their own size whenever a full walk is checked: every sequence test starts on an aligned address with a power-of-two pivot. Unaligned pointers and odd pivots appear only in the single-step sweep, where the expected value comes straight from the mirrored-add formula.

// File: rtl/brev_addr_pkg.sv
package brev_addr_pkg;
  localparam logic [2:0] AM_INDIRECT = 3'd0;
  localparam logic [2:0] AM_POST_DEC = 3'd1;
  localparam logic [2:0] AM_POST_INC = 3'd2;
  localparam logic [2:0] AM_PRE_DEC  = 3'd3;
  localparam logic [2:0] AM_PRE_INC  = 3'd4;

  typedef struct packed {
    logic pre;   // address used for the access is the updated one
    logic inc;   // pointer moves upward
    logic dec;   // pointer moves downward
  } amode_dec_t;
endpackage

// File: rtl/brev_mode_decode.sv
module brev_mode_decode
  import brev_addr_pkg::*;
(
  input  logic [2:0] amode,
  output amode_dec_t dec
);
  always_comb begin
    dec = '0;
    unique case (amode)
      AM_POST_DEC: dec.dec = 1'b1;
      AM_POST_INC: dec.inc = 1'b1;
      AM_PRE_DEC:  begin dec.dec = 1'b1; dec.pre = 1'b1; end
      AM_PRE_INC:  begin dec.inc = 1'b1; dec.pre = 1'b1; end
      default:     dec = '0;
    endcase
  end
endmodule

// File: rtl/brev_gate.sv
module brev_gate #(
  parameter int SEL_W     = 4,
  parameter int STACK_SEL = 15
) (
  input  logic             rev_en,
  input  logic [SEL_W-1:0] ptr_sel,
  input  logic             inc_mode,
  input  logic             is_byte,
  output logic             active
);
  localparam logic [SEL_W-1:0] STACK_IDX = SEL_W'(STACK_SEL);

  logic sel_ok;
  assign sel_ok = (ptr_sel != STACK_IDX);
  assign active = rev_en & sel_ok & inc_mode & ~is_byte;
endmodule

// File: rtl/brev_rc_adder.sv
// Reverse-carry adder: carries travel from bit i+1 into bit i; carry out of bit 0 is lost.
module brev_rc_adder #(
  parameter int W = 15
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] carry;
  assign carry[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign sum[i]   = a[i] ^ b[i] ^ carry[i+1];
    assign carry[i] = (a[i] & b[i]) | (a[i] & carry[i+1]) | (b[i] & carry[i+1]);
  end
endmodule

// File: rtl/brev_seq_step.sv
module brev_seq_step
  import brev_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] ptr,
  input  amode_dec_t        dec,
  input  logic              is_byte,
  output logic [ADDR_W-1:0] next
);
  logic [ADDR_W-1:0] size;
  assign size = is_byte ? ADDR_W'(1) : ADDR_W'(2);

  always_comb begin
    if (dec.inc)      next = ptr + size;
    else if (dec.dec) next = ptr - size;
    else              next = ptr;
  end
endmodule

// File: rtl/brev_wr_agen.sv
module brev_wr_agen
  import brev_addr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SEL_W     = 4,
  parameter int STACK_SEL = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic [ADDR_W-2:0] modifier,
  input  logic              rev_en,
  input  logic [SEL_W-1:0]  ptr_sel,
  input  logic [2:0]        amode,
  input  logic              is_byte,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ea_out,
  output logic [ADDR_W-1:0] ptr_next,
  output logic              rev_applied,
  output logic              modulo_inhibit
);
  localparam int WORD_W = ADDR_W - 1;

  amode_dec_t        dec;
  logic              active;
  logic [ADDR_W-1:0] seq_next;
  logic [WORD_W-1:0] rev_word;
  logic [ADDR_W-1:0] rev_next;
  logic [ADDR_W-1:0] old_word_ptr;
  logic [ADDR_W-1:0] upd_ptr;
  logic [ADDR_W-1:0] acc_ptr;

  brev_mode_decode u_dec (
    .amode (amode),
    .dec   (dec)
  );

  brev_gate #(.SEL_W(SEL_W), .STACK_SEL(STACK_SEL)) u_gate (
    .rev_en   (rev_en),
    .ptr_sel  (ptr_sel),
    .inc_mode (dec.inc),
    .is_byte  (is_byte),
    .active   (active)
  );

  brev_seq_step #(.ADDR_W(ADDR_W)) u_seq (
    .ptr     (ptr_in),
    .dec     (dec),
    .is_byte (is_byte),
    .next    (seq_next)
  );

  brev_rc_adder #(.W(WORD_W)) u_rca (
    .a   (ptr_in[ADDR_W-1:1]),
    .b   (modifier),
    .sum (rev_word)
  );

  assign rev_next     = {rev_word, 1'b0};
  assign old_word_ptr = {ptr_in[ADDR_W-1:1], 1'b0};

  always_comb begin
    if (active) begin
      upd_ptr = rev_next;
      acc_ptr = dec.pre ? rev_next : old_word_ptr;
    end else begin
      upd_ptr = seq_next;
      acc_ptr = dec.pre ? seq_next : ptr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      ea_out         <= '0;
      ptr_next       <= '0;
      rev_applied    <= 1'b0;
      modulo_inhibit <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        ea_out         <= acc_ptr;
        ptr_next       <= upd_ptr;
        rev_applied    <= active;
        modulo_inhibit <= active;
      end
    end
  end
endmodule

// File: rtl/brev_wr_agen_chk.sv
module brev_wr_agen_chk
  import brev_addr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SEL_W     = 4,
  parameter int STACK_SEL = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] ptr_in,
  input logic [SEL_W-1:0]  ptr_sel,
  input logic [2:0]        amode,
  input logic              is_byte,
  input logic              out_valid,
  input logic [ADDR_W-1:0] ea_out,
  input logic [ADDR_W-1:0] ptr_next,
  input logic              rev_applied
);
  assert_stack_never_rev_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(ptr_sel == SEL_W'(STACK_SEL)) |-> !rev_applied);

  assert_byte_preinc_seq_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(amode == AM_PRE_INC && is_byte) |-> ea_out == $past(ptr_in) + ADDR_W'(1));

  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    rev_applied |-> (!ea_out[0] && !ptr_next[0]));

  assert_post_uses_old_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(amode == AM_POST_INC) |-> ea_out[ADDR_W-1:1] == $past(ptr_in[ADDR_W-1:1]));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && $stable(ea_out) && $stable(ptr_next)));
endmodule

bind brev_wr_agen brev_wr_agen_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .STACK_SEL(STACK_SEL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .ptr_in      (ptr_in),
  .ptr_sel     (ptr_sel),
  .amode       (amode),
  .is_byte     (is_byte),
  .out_valid   (out_valid),
  .ea_out      (ea_out),
  .ptr_next    (ptr_next),
  .rev_applied (rev_applied)
);

// File: tb/brev_wr_agen_bench.sv
`timescale 1ns/1ps
module brev_wr_agen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] ptr_in = '0;
  logic [14:0] modifier = '0;
  logic        rev_en = 1'b0;
  logic [3:0]  ptr_sel = '0;
  logic [2:0]  amode = '0;
  logic        is_byte = 1'b0;
  logic        out_valid;
  logic [15:0] ea_out;
  logic [15:0] ptr_next;
  logic        rev_applied;
  logic        modulo_inhibit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brev_wr_agen u_brev_wr_agen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ptr_in(ptr_in),
    .modifier(modifier), .rev_en(rev_en), .ptr_sel(ptr_sel), .amode(amode),
    .is_byte(is_byte), .out_valid(out_valid), .ea_out(ea_out),
    .ptr_next(ptr_next), .rev_applied(rev_applied), .modulo_inhibit(modulo_inhibit)
  );

  function automatic logic [14:0] mirror15(input logic [14:0] x);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = x[14-i];
    return r;
  endfunction

  function automatic int mirror_n(input int x, input int n);
    int r = 0;
    for (int i = 0; i < n; i++) if (x[i]) r = r | (1 << (n - 1 - i));
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request, results sampled at the following falling edge
  task automatic issue(input logic [15:0] p, input logic [14:0] m, input logic en,
                       input logic [3:0] sel, input logic [2:0] am, input logic byt);
    @(negedge clk);
    ptr_in = p; modifier = m; rev_en = en; ptr_sel = sel; amode = am; is_byte = byt;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic model(input logic [15:0] p, input logic [14:0] m, input logic en,
                       input logic [3:0] sel, input logic [2:0] am, input logic byt,
                       output logic act, output logic [15:0] ea, output logic [15:0] nx);
    logic [14:0] w;
    logic [15:0] step;
    act = en && (sel != 4'd15) && !byt && (am == 3'd2 || am == 3'd4);
    if (act) begin
      w  = mirror15(mirror15(p[15:1]) + mirror15(m));
      nx = {w, 1'b0};
      ea = (am == 3'd4) ? nx : {p[15:1], 1'b0};
    end else begin
      step = byt ? 16'd1 : 16'd2;
      if (am == 3'd2 || am == 3'd4)      nx = p + step;
      else if (am == 3'd1 || am == 3'd3) nx = p - step;
      else                               nx = p;
      ea = (am == 3'd3 || am == 3'd4) ? nx : p;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic act_e;
    logic [15:0] ea_e, nx_e;
    logic [15:0] ptrs [5];
    logic [14:0] mods [3];
    logic [3:0]  sels [4];
    logic [15:0] base, cur, hold_ea, hold_nx;
    ptrs = '{16'h0000, 16'h1231, 16'hFFFE, 16'h0100, 16'h7FFF};
    mods = '{15'h0008, 15'h4000, 15'h0003};
    sels = '{4'd0, 4'd3, 4'd14, 4'd15};

    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 out_valid", 32'(out_valid), 0);
    check("R8 ea_out", 32'(ea_out), 0);
    check("R8 ptr_next", 32'(ptr_next), 0);
    check("R8 flags", {30'd0, rev_applied, modulo_inhibit}, 0);
    rst = 1'b0;

    // Sweep: R1 gating, R2 sequential, R3 reordered, R4 alignment, R5 ea choice, R6 inhibit
    for (int s = 0; s < 4; s++)
      for (int am = 0; am < 8; am++)
        for (int b = 0; b < 2; b++)
          for (int e = 0; e < 2; e++)
            for (int pi = 0; pi < 5; pi++)
              for (int mi = 0; mi < 3; mi++) begin
                issue(ptrs[pi], mods[mi], e[0], sels[s], am[2:0], b[0]);
                model(ptrs[pi], mods[mi], e[0], sels[s], am[2:0], b[0], act_e, ea_e, nx_e);
                check("R7 out_valid", 32'(out_valid), 1);
                check("R1 rev_applied", 32'(rev_applied), 32'(act_e));
                check("R6 modulo_inhibit", 32'(modulo_inhibit), 32'(act_e));
                if (act_e) begin
                  check("R3 ptr_next", 32'(ptr_next), 32'(nx_e));
                  check("R4 lsb", {30'd0, ea_out[0], ptr_next[0]}, 0);
                end else begin
                  check("R2 ptr_next", 32'(ptr_next), 32'(nx_e));
                end
                check("R5 ea_out", 32'(ea_out), 32'(ea_e));
              end

    // R7: idle cycles hold outputs while inputs change
    issue(16'h0040, 15'h0008, 1'b1, 4'd2, 3'd2, 1'b0);
    hold_ea = ea_out; hold_nx = ptr_next;
    @(negedge clk);
    ptr_in = 16'hABCD; amode = 3'd1; is_byte = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 idle out_valid", 32'(out_valid), 0);
    check("R7 idle ea_out", 32'(ea_out), 32'(hold_ea));
    check("R7 idle ptr_next", 32'(ptr_next), 32'(hold_nx));
    check("R7 idle flag", 32'(rev_applied), 1);

    // R9: full walks of aligned buffers, N = 2..6
    for (int n = 2; n <= 6; n++) begin
      base = 16'h0C00;
      cur  = base;
      for (int k = 0; k < (1 << n); k++) begin
        issue(cur, 15'(1 << (n - 1)), 1'b1, 4'd5, 3'd2, 1'b0);
        check("R9 walk order", 32'(ea_out), 32'(base) + 32'(2 * mirror_n(k, n)));
        cur = ptr_next;
      end
      check("R9 wrap to start", 32'(cur), 32'(base));
    end

    // R5/R9: pre-increment walk lands one step ahead
    cur = 16'h2000;
    for (int k = 0; k < 16; k++) begin
      issue(cur, 15'h0008, 1'b1, 4'd1, 3'd4, 1'b0);
      check("R5 pre walk", 32'(ea_out), 32'h2000 + 32'(2 * mirror_n((k + 1) % 16, 4)));
      cur = ptr_next;
    end

    // R8: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset again", {14'd0, out_valid, rev_applied, ea_out}, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule